// File: doc/BRIEF.md
# Stack Bytecode Execution Core

This block is a small stack machine. It reads one-byte opcodes from a byte-wide program memory and runs them against a 32-bit operand stack and a small bank of numbered local-variable slots. A start pulse clears the stack and the locals, then begins execution at a fixed address given by a parameter. The core works through each instruction in the same order: fetch the opcode, decode it, fetch the inline operand byte if there is one, execute, then fetch again. A return opcode ends the run.

The opcode set is small. The core can push a signed immediate byte or the constant zero. It can move values between the stack and local slots 1 to 3, and it can add the top two stack words. An illegal opcode stops the core with an error flag. So does popping an empty stack or pushing onto a full one. After a run, the host reads the local slots through a debug port that selects one slot at a time.

The program memory has a one-cycle read latency. The address presented in one cycle returns its byte in the next cycle.

Top module: `sbc_core`

## Requirements
- R1: After reset, done_o and err_o are 0, pmem_addr_o equals the RESET_PC parameter, and every local slot reads 0.
- R2: Opcode 0x10 pushes the following program byte, sign-extended to 32 bits, and execution continues at the byte after that operand.
- R3: Opcode 0x03 pushes the value 0.
- R4: Opcodes 0x3c, 0x3d and 0x3e pop the top of stack into local slots 1, 2 and 3. Opcodes 0x1b and 0x1c push the value of slot 1 and slot 2.
- R5: Opcode 0x60 pops two words and pushes their sum modulo 2^32.
- R6: Opcode 0xb1 ends the run. done_o rises in the cycle after that opcode's execute cycle and stays high until the next start. pmem_addr_o then stays fixed.
- R7: Counting the clock edge that samples start_i as edge 0, each instruction without an operand takes 3 edges and each 0x10 takes 4. The program 0x10 0x07 0x3c 0xb1 therefore shows done_o high first after edge 10.
- R8: An opcode that pops more words than the stack holds sets err_o and halts the core without raising done_o.
- R9: The stack holds STACK_DEPTH (default 8) words. Filling it exactly is legal. A push onto a full stack sets err_o and halts.
- R10: Any opcode outside the listed set (for example 0x00) sets err_o. err_o stays high until the next start.
- R11: start_i is ignored while a program runs. In the idle state, start_i clears done_o, err_o, the stack and every local slot, and restarts execution at RESET_PC.
- R12: dbg_data_o shows the slot selected by dbg_sel_i in the same cycle. Slot 0 is never written by any opcode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts a run when the core is idle |
| pmem_addr_o | output | ADDR_W | Program memory byte address |
| pmem_data_i | input | 8 | Program byte, valid one cycle after its address |
| done_o | output | 1 | Run ended on the return opcode |
| err_o | output | 1 | Run halted on a stack fault or an illegal opcode |
| dbg_sel_i | input | $clog2(NUM_LOCALS) | Local slot selected for debug read |
| dbg_data_o | output | DATA_W | Value of the selected local slot |

## Verification
The stack pointer, the program counter and the latched decode cannot be seen directly. Their faults show up only in the final local-slot values and in when done_o or err_o rises. If the pointer is off by one, the wrong slot value appears, or an error flag rises at the fill boundary, before the program would otherwise finish. If the counter is off by one, the core skips the operand byte or decodes it as an opcode, which usually trips err_o within a few instructions. Cycle-exact checks on the done edge catch any extra or missing FSM state as soon as the first run completes.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

   localparam logic [7:0] OPC_PUSHB  = 8'h10;
   localparam logic [7:0] OPC_PUSH0  = 8'h03;
   localparam logic [7:0] OPC_LOAD1  = 8'h1b;
   localparam logic [7:0] OPC_LOAD2  = 8'h1c;
   localparam logic [7:0] OPC_STORE1 = 8'h3c;
   localparam logic [7:0] OPC_STORE2 = 8'h3d;
   localparam logic [7:0] OPC_STORE3 = 8'h3e;
   localparam logic [7:0] OPC_ADD    = 8'h60;
   localparam logic [7:0] OPC_RET    = 8'hb1;

   typedef enum logic [2:0] {
      K_BAD, K_PUSHB, K_PUSH0, K_LOAD, K_STORE, K_ADD, K_RET
   } kind_e;

   typedef struct packed {
      kind_e      kind;
      logic       has_imm;
      logic [1:0] slot;
      logic [1:0] pops;
      logic       push;
   } dec_t;

   typedef enum logic [1:0] {
      STK_NONE, STK_PUSH, STK_POP, STK_REPL2
   } stk_op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_DECODE, S_OPND, S_EXEC
   } state_e;

endpackage

// File: rtl/sbc_decode.sv
module sbc_decode
   import sbc_pkg::*;
(
   input  logic [7:0] opc_i,
   output dec_t       dec_o
);

   always_comb begin
      dec_o = '{kind: K_BAD, has_imm: 1'b0, slot: 2'd0, pops: 2'd0, push: 1'b0};
      unique case (opc_i)
         OPC_PUSHB:  begin dec_o.kind = K_PUSHB; dec_o.has_imm = 1'b1; dec_o.push = 1'b1; end
         OPC_PUSH0:  begin dec_o.kind = K_PUSH0; dec_o.push = 1'b1; end
         OPC_LOAD1:  begin dec_o.kind = K_LOAD;  dec_o.slot = 2'd1; dec_o.push = 1'b1; end
         OPC_LOAD2:  begin dec_o.kind = K_LOAD;  dec_o.slot = 2'd2; dec_o.push = 1'b1; end
         OPC_STORE1: begin dec_o.kind = K_STORE; dec_o.slot = 2'd1; dec_o.pops = 2'd1; end
         OPC_STORE2: begin dec_o.kind = K_STORE; dec_o.slot = 2'd2; dec_o.pops = 2'd1; end
         OPC_STORE3: begin dec_o.kind = K_STORE; dec_o.slot = 2'd3; dec_o.pops = 2'd1; end
         OPC_ADD:    begin dec_o.kind = K_ADD;   dec_o.pops = 2'd2; dec_o.push = 1'b1; end
         OPC_RET:    begin dec_o.kind = K_RET; end
         default:    ;
      endcase
   end

endmodule

// File: rtl/sbc_stack.sv
module sbc_stack
   import sbc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 8,
   localparam int PTR_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  stk_op_e           op_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] tos_o,
   output logic [DATA_W-1:0] nos_o,
   output logic [PTR_W-1:0]  depth_o
);

   logic [DATA_W-1:0] ent [DEPTH];
   logic [PTR_W-1:0]  sp;

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic wr;
      assign wr = ((op_i == STK_PUSH)  && (sp == PTR_W'(g))) ||
                  ((op_i == STK_REPL2) && (sp == PTR_W'(g + 2)));
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i) ent[g] <= '0;
         else if (wr)         ent[g] <= wdata_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i) sp <= '0;
      else begin
         unique case (op_i)
            STK_PUSH:            sp <= sp + PTR_W'(1);
            STK_POP, STK_REPL2:  sp <= sp - PTR_W'(1);
            default:             ;
         endcase
      end
   end

   always_comb begin
      tos_o = '0;
      nos_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (sp == PTR_W'(i + 1)) tos_o = ent[i];
         if (sp == PTR_W'(i + 2)) nos_o = ent[i];
      end
   end

   assign depth_o = sp;

endmodule

// File: rtl/sbc_locals.sv
module sbc_locals #(
   parameter int DATA_W     = 32,
   parameter int NUM_LOCALS = 4,
   localparam int IDX_W     = $clog2(NUM_LOCALS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [IDX_W-1:0]  dbg_idx_i,
   output logic [DATA_W-1:0] dbg_data_o
);

   logic [DATA_W-1:0] slot [NUM_LOCALS];

   for (genvar g = 0; g < NUM_LOCALS; g++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n || clr_i)                        slot[g] <= '0;
         else if (we_i && (widx_i == IDX_W'(g)))     slot[g] <= wdata_i;
      end
   end

   always_comb begin
      rdata_o    = '0;
      dbg_data_o = '0;
      for (int i = 0; i < NUM_LOCALS; i++) begin
         if (ridx_i    == IDX_W'(i)) rdata_o    = slot[i];
         if (dbg_idx_i == IDX_W'(i)) dbg_data_o = slot[i];
      end
   end

endmodule

// File: rtl/sbc_core.sv
module sbc_core
   import sbc_pkg::*;
#(
   parameter int          DATA_W      = 32,
   parameter int          ADDR_W      = 8,
   parameter int          STACK_DEPTH = 8,
   parameter int          NUM_LOCALS  = 4,
   parameter logic [7:0]  RESET_PC    = 8'h00,
   localparam int         PTR_W       = $clog2(STACK_DEPTH + 1),
   localparam int         IDX_W       = $clog2(NUM_LOCALS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   output logic [ADDR_W-1:0] pmem_addr_o,
   input  logic [7:0]        pmem_data_i,
   output logic              done_o,
   output logic              err_o,
   input  logic [IDX_W-1:0]  dbg_sel_i,
   output logic [DATA_W-1:0] dbg_data_o
);

   if (DATA_W < 16) begin : g_bad_data_w
      $error("sbc_core: DATA_W must be at least 16");
   end
   if (STACK_DEPTH < 2) begin : g_bad_depth
      $error("sbc_core: STACK_DEPTH must be at least 2");
   end
   if (NUM_LOCALS < 4) begin : g_bad_locals
      $error("sbc_core: NUM_LOCALS must be at least 4");
   end
   if (ADDR_W < 8) begin : g_bad_addr_w
      $error("sbc_core: ADDR_W must be at least 8");
   end

   state_e            state;
   logic [ADDR_W-1:0] pc;
   dec_t              dec_d, dec_q;
   logic              done_q, err_q;

   stk_op_e           stk_op;
   logic [DATA_W-1:0] stk_wdata, tos, nos;
   logic [PTR_W-1:0]  stk_depth;
   logic              clr;

   logic              lcl_we;
   logic [DATA_W-1:0] lcl_rdata;

   logic              underflow, overflow, fault;
   logic [PTR_W:0]    depth_after;

   sbc_decode u_dec (
      .opc_i (pmem_data_i),
      .dec_o (dec_d)
   );

   sbc_stack #(.DATA_W(DATA_W), .DEPTH(STACK_DEPTH)) u_stk (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (clr),
      .op_i    (stk_op),
      .wdata_i (stk_wdata),
      .tos_o   (tos),
      .nos_o   (nos),
      .depth_o (stk_depth)
   );

   sbc_locals #(.DATA_W(DATA_W), .NUM_LOCALS(NUM_LOCALS)) u_lcl (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (clr),
      .we_i       (lcl_we),
      .widx_i     (IDX_W'(dec_q.slot)),
      .wdata_i    (tos),
      .ridx_i     (IDX_W'(dec_q.slot)),
      .rdata_o    (lcl_rdata),
      .dbg_idx_i  (dbg_sel_i),
      .dbg_data_o (dbg_data_o)
   );

   assign clr = (state == S_IDLE) && start_i;

   assign underflow   = {1'b0, stk_depth} < (PTR_W + 1)'(dec_q.pops);
   assign depth_after = {1'b0, stk_depth} + (PTR_W + 1)'(dec_q.push)
                        - (PTR_W + 1)'(dec_q.pops);
   assign overflow    = !underflow && (depth_after > (PTR_W + 1)'(STACK_DEPTH));
   assign fault       = (dec_q.kind == K_BAD) || underflow || overflow;

   always_comb begin
      stk_op    = STK_NONE;
      stk_wdata = '0;
      lcl_we    = 1'b0;
      if (state == S_EXEC && !fault) begin
         unique case (dec_q.kind)
            K_PUSHB: begin
               stk_op    = STK_PUSH;
               stk_wdata = {{(DATA_W - 8){pmem_data_i[7]}}, pmem_data_i};
            end
            K_PUSH0: stk_op = STK_PUSH;
            K_LOAD: begin
               stk_op    = STK_PUSH;
               stk_wdata = lcl_rdata;
            end
            K_STORE: begin
               stk_op = STK_POP;
               lcl_we = 1'b1;
            end
            K_ADD: begin
               stk_op    = STK_REPL2;
               stk_wdata = tos + nos;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= S_IDLE;
         pc     <= ADDR_W'(RESET_PC);
         dec_q  <= '{kind: K_BAD, has_imm: 1'b0, slot: 2'd0, pops: 2'd0, push: 1'b0};
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         unique case (state)
            S_IDLE: if (start_i) begin
               pc     <= ADDR_W'(RESET_PC);
               done_q <= 1'b0;
               err_q  <= 1'b0;
               state  <= S_FETCH;
            end
            S_FETCH: state <= S_DECODE;
            S_DECODE: begin
               dec_q <= dec_d;
               pc    <= pc + ADDR_W'(1);
               state <= dec_d.has_imm ? S_OPND : S_EXEC;
            end
            S_OPND: state <= S_EXEC;
            S_EXEC: begin
               if (fault) begin
                  err_q <= 1'b1;
                  state <= S_IDLE;
               end else if (dec_q.kind == K_RET) begin
                  done_q <= 1'b1;
                  state  <= S_IDLE;
               end else begin
                  if (dec_q.has_imm) pc <= pc + ADDR_W'(1);
                  state <= S_FETCH;
               end
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign pmem_addr_o = pc;
   assign done_o      = done_q;
   assign err_o       = err_q;

endmodule

// File: rtl/sbc_core_chk.sv
module sbc_core_chk #(
   parameter int ADDR_W = 8,
   parameter int PTR_W  = 4,
   parameter int DEPTH  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              done_o,
   input logic              err_o,
   input logic [ADDR_W-1:0] pmem_addr_o,
   input logic [PTR_W-1:0]  depth
);

   // R6
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && !start_i |=> done_o);

   // R10
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_o && !start_i |=> err_o);

   // R8
   done_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && err_o));

   // R11
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && (done_o || err_o) |=> !done_o && !err_o);

   // R6
   halt_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || err_o) && !start_i |=> $stable(pmem_addr_o));

   // R9
   depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      depth <= PTR_W'(DEPTH));

endmodule

bind sbc_core sbc_core_chk #(
   .ADDR_W (ADDR_W),
   .PTR_W  (PTR_W),
   .DEPTH  (STACK_DEPTH)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .done_o      (done_o),
   .err_o       (err_o),
   .pmem_addr_o (pmem_addr_o),
   .depth       (stk_depth)
);

// File: tb/sbc_core_tb.sv
module sbc_core_tb;

   localparam int         CLK_PERIOD = 10;
   localparam logic [7:0] BASE       = 8'h10;
   localparam int         WDOG_LIMIT = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [7:0]  addr;
   logic [7:0]  rdata = 8'h00;
   logic        done, err;
   logic [1:0]  dbg_sel = 2'd0;
   logic [31:0] dbg_data;

   logic [7:0]  mem [256];
   int          n_tests = 0;
   int          n_fail  = 0;
   int          cycles  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   always @(posedge clk) rdata <= mem[addr];

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WDOG_LIMIT) begin
         $display("FAIL watchdog: actual %0d cycles expected < %0d", cycles, WDOG_LIMIT);
         $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
         $finish;
      end
   end

   sbc_core #(.RESET_PC(BASE)) u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .pmem_addr_o (addr),
      .pmem_data_i (rdata),
      .done_o      (done),
      .err_o       (err),
      .dbg_sel_i   (dbg_sel),
      .dbg_data_o  (dbg_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
   endtask

   task automatic put(input int idx, input logic [7:0] v);
      mem[BASE + idx] = v;
   endtask

   task automatic read_local(input int s, output logic [31:0] v);
      dbg_sel = 2'(s);
      #1;
      v = dbg_data;
   endtask

   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic run_until_halt();
      pulse_start();
      for (int i = 0; i < 3000; i++) begin
         if (done || err) break;
         @(negedge clk);
      end
   endtask

   task automatic load_main();
      clear_mem();
      put(0, 8'h10); put(1, 8'h0f); put(2, 8'h3c);
      put(3, 8'h10); put(4, 8'h09); put(5, 8'h3d);
      put(6, 8'h03); put(7, 8'h3e);
      put(8, 8'h1b); put(9, 8'h1c); put(10, 8'h60); put(11, 8'h3e);
      put(12, 8'hb1);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 done", 32'(done), 0);
      check("R1 err", 32'(err), 0);
      check("R1 addr", 32'(addr), 32'(BASE));
      for (int s = 0; s < 4; s++) begin
         read_local(s, v);
         check("R1 local", v, 0);
      end
   endtask

   task automatic t_main();
      logic [31:0] v;
      load_main();
      run_until_halt();
      check("R6 done", 32'(done), 1);
      check("R6 err", 32'(err), 0);
      read_local(1, v); check("R2 R4 local1", v, 15);
      read_local(2, v); check("R4 local2", v, 9);
      read_local(3, v); check("R3 R5 local3", v, 24);
      read_local(0, v); check("R12 slot0", v, 0);
      check("R6 halt addr", 32'(addr), 32'(BASE) + 13);
      repeat (5) @(negedge clk);
      check("R6 done held", 32'(done), 1);
      check("R6 addr held", 32'(addr), 32'(BASE) + 13);
   endtask

   task automatic t_timing();
      logic [31:0] v;
      clear_mem();
      put(0, 8'h10); put(1, 8'h07); put(2, 8'h3c); put(3, 8'hb1);
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int e = 1; e <= 9; e++) begin
         @(posedge clk);
         @(negedge clk);
         check("R7 done low before edge 10", 32'(done), 0);
      end
      @(posedge clk);
      @(negedge clk);
      check("R7 done at edge 10", 32'(done), 1);
      read_local(1, v);
      check("R7 local1", v, 7);
   endtask

   task automatic t_sext_wrap();
      logic [31:0] v;
      clear_mem();
      put(0, 8'h10); put(1, 8'hff); put(2, 8'h3d);
      put(3, 8'h1c); put(4, 8'h10); put(5, 8'h02); put(6, 8'h60); put(7, 8'h3c);
      put(8, 8'h10); put(9, 8'h80); put(10, 8'h3e);
      put(11, 8'hb1);
      run_until_halt();
      check("R2 done", 32'(done), 1);
      read_local(2, v); check("R2 sext ff", v, 32'hffff_ffff);
      read_local(1, v); check("R5 wrap", v, 32'h0000_0001);
      read_local(3, v); check("R2 sext 80", v, 32'hffff_ff80);
   endtask

   task automatic t_underflow();
      clear_mem();
      put(0, 8'h60); put(1, 8'hb1);
      run_until_halt();
      check("R8 add empty err", 32'(err), 1);
      check("R8 add empty done", 32'(done), 0);
      clear_mem();
      put(0, 8'h03); put(1, 8'h3c); put(2, 8'h3d); put(3, 8'hb1);
      run_until_halt();
      check("R8 store empty err", 32'(err), 1);
      check("R8 store empty done", 32'(done), 0);
   endtask

   task automatic t_depth();
      logic [31:0] v;
      clear_mem();
      for (int i = 0; i < 9; i++) put(i, 8'h03);
      put(9, 8'hb1);
      run_until_halt();
      check("R9 overflow err", 32'(err), 1);
      check("R9 overflow done", 32'(done), 0);
      clear_mem();
      for (int i = 0; i < 8; i++) begin
         put(2 * i, 8'h10);
         put(2 * i + 1, 8'(i + 1));
      end
      for (int i = 0; i < 7; i++) put(16 + i, 8'h60);
      put(23, 8'h3e); put(24, 8'hb1);
      run_until_halt();
      check("R9 full err", 32'(err), 0);
      check("R9 full done", 32'(done), 1);
      read_local(3, v); check("R9 full sum", v, 36);
   endtask

   task automatic t_bad_opcode();
      clear_mem();
      put(0, 8'h03); put(1, 8'h00); put(2, 8'hb1);
      run_until_halt();
      check("R10 err", 32'(err), 1);
      check("R10 done", 32'(done), 0);
      repeat (6) @(negedge clk);
      check("R10 err held", 32'(err), 1);
   endtask

   task automatic t_restart();
      logic [31:0] v;
      load_main();
      pulse_start();
      repeat (6) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         if (done || err) break;
         @(negedge clk);
      end
      check("R11 err cleared", 32'(err), 0);
      check("R11 mid start ignored done", 32'(done), 1);
      read_local(3, v); check("R11 mid start ignored", v, 24);
      clear_mem();
      put(0, 8'hb1);
      run_until_halt();
      check("R11 done again", 32'(done), 1);
      read_local(1, v); check("R11 locals cleared 1", v, 0);
      read_local(3, v); check("R11 locals cleared 3", v, 0);
   endtask

   initial begin
      clear_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_main();
      t_timing();
      t_sext_wrap();
      t_underflow();
      t_depth();
      t_bad_opcode();
      t_restart();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule